// File: doc/BRIEF.md
# Preloaded Prescaled 8-bit Timer

This block is an 8-bit up-counter that advances once per prescaler period, where the period is a power-of-two number of system clock cycles picked by a 3-bit select field. Software sees two byte-wide registers. One is a data register: a write stores a reload value, and a read returns the live count. The other is a control register that holds the ratio select and a run bit. When the count steps past FFh, the counter takes the reload value and raises an interrupt request flag. The flag stays set until a dedicated clear input is pulsed.

The prescaler does not produce a derived clock. It emits a one-cycle enable pulse in the system clock domain. Counting is governed by a two-state machine. **ST_HALT** holds the count and keeps the prescaler at zero. **ST_RUN** lets the prescaler run and the counter step. The **start** transition (ST_HALT to ST_RUN) fires on a control write with bit 4 set. The **stop** transition (ST_RUN to ST_HALT) fires on a control write with bit 4 clear. Any other control write leaves the state unchanged. A system that needs two timers places two instances.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the count, the reload value and the control byte all read 0, the flag is 0, and the count does not change while no write occurs.
- R2: A write to the data register (addr 0) changes only the reload value; the count read back is not altered by the write, whether the timer is running or halted.
- R3: Reading addr 0 returns the current count; reading addr 1 returns the last byte written to the control register.
- R4: In ST_RUN, with select code s in control bits 2..0, the count rises by exactly 1 every 2^(4+s) clock cycles (000 gives /16, 111 gives /2048).
- R5: A control write with bit 4 = 0 (stop) freezes the count for as long as the timer stays in ST_HALT.
- R6: On the prescaler period in which the count is FFh, the count becomes the reload value held at that time instead of 00h, and the flag is set on the same edge.
- R7: The flag stays 1 until flag_clr is sampled high; when flag_clr and an overflow fall on the same edge, the flag ends up 1.
- R8: The prescaler is held at zero in ST_HALT, so after a start write the first increment lands exactly 2^(4+s) clock edges after the write edge, regardless of any partial period counted before the stop.
- R9: Control bits 3, 5, 6 and 7 have no effect on counting; they are only stored and read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 1 | Register select: 0 data/reload, 1 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register chosen by addr |
| flag_clr | input | 1 | Clears the interrupt request flag |
| irq_flag | output | 8'b1 == 1 ? 1 : 1 | Interrupt request flag, set on overflow |

## Verification
Suppose the prescaler state is wrong, for example not cleared on stop or wrapping at the wrong terminal value. The first increment after a start write then moves away from its exact edge, and this shows on the count read back within one prescale period. A wrong counter or reload path shows at the first overflow: the data read at the edge after FFh is something other than the reload byte. A flag with the wrong priority shows on the single edge where a clear meets an overflow. For that reason the bench aims both of these events at one known edge.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int DATA_W    = 8;
    localparam int SEL_W     = 3;
    localparam int BASE_LOG2 = 4;
    localparam int RUN_BIT   = 4;
    localparam int SEL_LSB   = 0;

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
    parameter int SEL_W     = 3,
    parameter int BASE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int SEL_MAX = (1 << SEL_W) - 1;
    localparam int PS_W    = BASE_LOG2 + SEL_MAX;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] term;

    // terminal value 2^(BASE_LOG2+sel)-1, made by shifting an all-ones word
    assign term = {PS_W{1'b1}} >> (SEL_W'(SEL_MAX) - sel);
    // >= so that a ratio lowered while running still wraps
    assign tick = run && (ps_q >= term);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_q + 1'b1;
        end
    end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] preload,
    output logic [W-1:0] count,
    output logic         ovf
);
    logic [W-1:0] count_q;

    assign ovf   = tick && (count_q == {W{1'b1}});
    assign count = count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (ovf) begin
            count_q <= preload;
        end else if (tick) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/ptmr_flag.sv
module ptmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import ptmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              flag_clr,
    output logic              irq_flag
);
    tmr_state_e        state_q, state_d;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] preload_q;
    logic [DATA_W-1:0] count_q;
    logic              run;
    logic              ps_tick;
    logic              ovf;
    logic              ctrl_wr;
    logic              data_wr;

    assign ctrl_wr = wr_en && (addr == ADDR_CTRL);
    assign data_wr = wr_en && (addr == ADDR_DATA);

    // next-state: start / stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (ctrl_wr && wdata[RUN_BIT])  state_d = ST_RUN;
            ST_RUN:  if (ctrl_wr && !wdata[RUN_BIT]) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs of the state machine
    always_comb begin
        unique case (state_q)
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            preload_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q    <= wdata;
            if (data_wr) preload_q <= wdata;
        end
    end

    ptmr_prescaler #(
        .SEL_W     (SEL_W),
        .BASE_LOG2 (BASE_LOG2)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (ctrl_q[SEL_LSB +: SEL_W]),
        .tick  (ps_tick)
    );

    ptmr_counter #(
        .W (DATA_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (ps_tick),
        .preload (preload_q),
        .count   (count_q),
        .ovf     (ovf)
    );

    ptmr_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ovf),
        .clr   (flag_clr),
        .flag  (irq_flag)
    );

    assign rdata = (addr == ADDR_CTRL) ? ctrl_q : count_q;
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic       tick,
    input logic [7:0] count,
    input logic [7:0] preload,
    input logic       flag,
    input logic       flag_clr
);
    assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !tick) |=> $stable(count));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count != 8'hFF) |=> (count == $past(count) + 8'd1));

    assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == 8'hFF) |=> (count == $past(preload) && flag));

    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(tick && count == 8'hFF)) |=> !flag);

    assert_tick_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);
endmodule

bind prescaled_timer ptmr_checker u_ptmr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (ps_tick),
    .count    (count_q),
    .preload  (preload_q),
    .flag     (irq_flag),
    .flag_clr (flag_clr)
);

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;
    localparam time CLK_P    = 20ns;
    localparam int  WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       flag_clr = 1'b0;
    logic       irq_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    prescaled_timer i_prescaled_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .flag_clr (flag_clr),
        .irq_flag (irq_flag)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_count(output logic [7:0] v);
        reg_read(1'b0, v);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        reg_read(1'b0, v); chk("R1 count", v, 8'h00);
        reg_read(1'b1, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 flag", {7'd0, irq_flag}, 8'h00);
        edges(50);
        read_count(v); chk("R1 idle count", v, 8'h00);
    endtask

    task automatic t_preload_only;
        logic [7:0] v;
        reg_write(1'b0, 8'hF0);
        read_count(v); chk("R2 halted write", v, 8'h00);
    endtask

    task automatic t_first_ticks;
        logic [7:0] v;
        reg_write(1'b1, 8'h90);
        edges(15);
        read_count(v); chk("R8 before first", v, 8'h00);
        edges(1);
        read_count(v); chk("R4 first /16", v, 8'h01);
        reg_read(1'b1, v); chk("R3 ctrl read", v, 8'h90);
        edges(48);
        read_count(v); chk("R4 three more", v, 8'h04);
    endtask

    task automatic t_hold;
        logic [7:0] v;
        reg_write(1'b1, 8'h80);
        edges(100);
        read_count(v); chk("R5 hold", v, 8'h04);
        reg_read(1'b1, v); chk("R3 ctrl stop", v, 8'h80);
    endtask

    task automatic t_ratio(input logic [2:0] s, input string req);
        logic [7:0] c0, v;
        int n;
        reg_write(1'b1, 8'h80);
        read_count(c0);
        n = 16 << s;
        reg_write(1'b1, {5'b10010, s});
        edges(n - 1);
        read_count(v); chk({req, " early"}, v, c0);
        edges(1);
        read_count(v); chk({req, " on time"}, v, c0 + 8'd1);
    endtask

    task automatic t_restart;
        logic [7:0] c0, v;
        reg_write(1'b1, 8'h80);
        read_count(c0);
        reg_write(1'b1, 8'h90);
        edges(9);
        reg_write(1'b1, 8'h80);
        edges(5);
        reg_write(1'b1, 8'h90);
        edges(15);
        read_count(v); chk("R8 no carry-over", v, c0);
        edges(1);
        read_count(v); chk("R8 full period", v, c0 + 8'd1);
    endtask

    task automatic t_reserved;
        logic [7:0] c0, v;
        reg_write(1'b1, 8'h00);
        read_count(c0);
        reg_write(1'b1, 8'hF8);
        reg_read(1'b1, v); chk("R3 ctrl reserved read", v, 8'hF8);
        edges(15);
        read_count(v); chk("R9 early", v, c0);
        edges(1);
        read_count(v); chk("R9 /16 kept", v, c0 + 8'd1);
    endtask

    task automatic t_overflow;
        logic [7:0] c0, v;
        int n;
        reg_write(1'b1, 8'h80);
        read_count(c0);
        n = 16 * (256 - int'(c0));
        reg_write(1'b1, 8'h90);
        edges(n - 1);
        read_count(v); chk("R6 at FF", v, 8'hFF);
        chk("R6 flag low before", {7'd0, irq_flag}, 8'h00);
        edges(1);
        read_count(v); chk("R6 reload", v, 8'hF0);
        chk("R6 flag set", {7'd0, irq_flag}, 8'h01);
        edges(255);
        read_count(v); chk("R6 second FF", v, 8'hFF);
        edges(1);
        read_count(v); chk("R6 second reload", v, 8'hF0);
    endtask

    task automatic t_clear;
        logic [7:0] v;
        // now half a cycle after overflow edge O
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R7 cleared", {7'd0, irq_flag}, 8'h00);
        edges(10);
        chk("R7 stays clear", {7'd0, irq_flag}, 8'h00);
        edges(244);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R7 set wins", {7'd0, irq_flag}, 8'h01);
        read_count(v); chk("R6 reload at clash", v, 8'hF0);
        reg_write(1'b0, 8'h10);
        read_count(v); chk("R2 running write", v, 8'hF0);
        edges(20);
        chk("R7 flag held", {7'd0, irq_flag}, 8'h01);
        edges(233);
        read_count(v); chk("R6 FF before new reload", v, 8'hFF);
        edges(1);
        read_count(v); chk("R6 new reload value", v, 8'h10);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_preload_only();
        t_first_ticks();
        t_hold();
        t_ratio(3'd3, "R4 /128");
        t_ratio(3'd7, "R4 /2048");
        t_restart();
        t_reserved();
        t_overflow();
        t_clear();
        done = 1;
        report();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule